// File: doc/BRIEF.md
# Ethernet DMA interrupt status and control unit

This unit is the register-facing interrupt and DMA control block for a small Ethernet DMA engine. The transmit and receive engines send it single-cycle event pulses. It latches each pulse into a pending register that software clears by writing 1s. It holds the run enables and interrupt enables for both DMA directions. When a fatal error is reported, it drops both DMA run enables in hardware. It drives one level interrupt line.

Software reaches the unit through a plain register port: a 2-bit address, a write strobe with 32-bit write data, and combinational read data. Address 0 is the status word. It holds the pending events together with live copies of the receive and transmit ring read pointers and of the sequence number of the frame at the head of the receive queue. Address 1 is the control word. Address 2 reports the receive FIFO pointers and the current fill level.

Top module: `ethdma_irq_ctrl`

## Requirements
- R1: An input event pulse in cycle N sets its pending bit, and the bit reads back from cycle N+1. Status bit order:
  - 0 TX ring empty
  - 1 TX packet sent
  - 2 link failure
  - 3 memory error
  - 4 TX abort
  - 5 RX threshold
  - 6 RX underflow
  - 7 RX overflow
- R2: A write to address 0 clears every pending bit whose write-data bit is 1. Pending bits written with 0 are left unchanged.
- R3: If an event arrives in the same cycle as a write that clears its bit, the bit stays set.
- R4: A memory error, TX abort or RX overflow event clears both DMA run enables (control bits 1 and 15) on the next edge. This overrides a control write in the same cycle. Other events leave the run enables unchanged.
- R5: Control word fields:
  - bit 0: TX-empty interrupt enable
  - bit 1: TX DMA run
  - bits 8..4: RX depth threshold
  - bit 9: RX interrupt enable
  - bits 14..12: RX data offset
  - bit 15: RX DMA run

  Bits 2 and 3 and bits 31..16 are not writable and read 0. The output pins follow the stored fields.
- R6: `irq` is high when any pending bit is set and enabled. Bit 0 is enabled by control bit 0 and bit 5 by control bit 9. Bits 1, 2, 3, 4, 6 and 7 are always enabled.
- R7: Address 2 reads:
  - write pointer in bits 19..16
  - read pointer in bits 11..8
  - fill level in bits 4..0, where fill level = (write − read) mod 16

  All other bits read 0.
- R8: The status word carries:
  - RX read pointer in bits 11..8
  - TX read pointer in bits 24..16
  - head sequence number in bits 29..25

  Bits 15..12 and 31..30 read 0, and address 3 reads all zeros.
- R9: While RX DMA runs and the fill level differs from the depth threshold, pending bit 5 is set on every edge.
- R10: After reset, both enables and all pending bits are 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| ev_tx_empty | input | 1 | TX ring empty pulse |
| ev_tx_sent | input | 1 | TX packet sent pulse |
| ev_link_fail | input | 1 | Link failure pulse |
| ev_mem_err | input | 1 | Memory error pulse (fatal) |
| ev_tx_abort | input | 1 | TX abort pulse (fatal) |
| ev_rx_underflow | input | 1 | RX underflow pulse |
| ev_rx_overflow | input | 1 | RX overflow pulse (fatal) |
| tx_rd_ptr | input | 9 | TX ring read pointer |
| rx_wr_ptr | input | 4 | RX FIFO write pointer |
| rx_rd_ptr | input | 4 | RX FIFO read pointer |
| rx_head_seq | input | 5 | Sequence number of the head frame |
| irq | output | 1 | Interrupt request |
| tx_dma_en | output | 1 | TX DMA run enable |
| rx_dma_en | output | 1 | RX DMA run enable |
| rx_depth_thr | output | 5 | RX depth threshold |
| rx_data_offset | output | 3 | RX data start offset |

## Verification
The bench builds the unit with its default parameters: 9-bit TX pointer, 4-bit RX pointers and a 5-bit sequence number. These widths fill the status and FIFO-info fields exactly, so every alias bit and every zero gap between fields can be observed. The 4-bit RX pointers make a wrap-around fill level reachable with small pointer values. That lets the bench test both a threshold that matches and one that does not. No event interface is a stream, so none of the ports carries back-pressure.

// File: rtl/ethdma_irq_pkg.sv
package ethdma_irq_pkg;
  localparam int NUM_EVT = 8;
  localparam int CTRL_W  = 16;
  localparam int DEPTH_W = 5;
  localparam int OFF_W   = 3;

  // pending bit positions
  localparam int EV_TX_EMPTY = 0;
  localparam int EV_TX_SENT  = 1;
  localparam int EV_LINK     = 2;
  localparam int EV_MEM      = 3;
  localparam int EV_ABORT    = 4;
  localparam int EV_RX_THR   = 5;
  localparam int EV_RX_UNDER = 6;
  localparam int EV_RX_OVER  = 7;

  // control word positions
  localparam int CB_TXE_IE    = 0;
  localparam int CB_TX_RUN    = 1;
  localparam int CB_DEPTH_LSB = 4;
  localparam int CB_RX_IE     = 9;
  localparam int CB_OFF_LSB   = 12;
  localparam int CB_RX_RUN    = 15;
  localparam logic [CTRL_W-1:0] CTRL_WMASK = 16'hFFF3;

  localparam logic [NUM_EVT-1:0] FATAL_MASK  = 8'h98;
  localparam logic [NUM_EVT-1:0] ALWAYS_MASK = 8'hDE;

  // status / fifo-info field positions
  localparam int ST_RXPTR_LSB = 8;
  localparam int ST_TXPTR_LSB = 16;
  localparam int ST_SEQ_LSB   = 25;
  localparam int FI_WR_LSB    = 16;
  localparam int FI_RD_LSB    = 8;

  typedef enum logic [1:0] {
    RS_STATUS = 2'd0,
    RS_CTRL   = 2'd1,
    RS_FIFO   = 2'd2,
    RS_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ethdma_pend_w1c.sv
module ethdma_pend_w1c #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        pend_o[i] <= 1'b0;
      else if (set_i[i]) pend_o[i] <= 1'b1;   // event beats clear
      else if (clr_i[i]) pend_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ethdma_ctrl_reg.sv
module ethdma_ctrl_reg
  import ethdma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              fatal_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [CTRL_W-1:0] nxt;

  always_comb begin
    nxt = wr_i ? (wdata_i & CTRL_WMASK) : ctrl_o;
    if (fatal_i) begin
      nxt[CB_TX_RUN] = 1'b0;
      nxt[CB_RX_RUN] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_o <= '0;
    else        ctrl_o <= nxt;
  end
endmodule

// File: rtl/ethdma_rx_meter.sv
module ethdma_rx_meter
  import ethdma_irq_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic [PTR_W-1:0]   wr_ptr_i,
  input  logic [PTR_W-1:0]   rd_ptr_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic               run_i,
  output logic [DEPTH_W-1:0] level_o,
  output logic               thr_evt_o
);
  logic [PTR_W-1:0] diff;

  always_comb begin
    diff      = wr_ptr_i - rd_ptr_i;
    level_o   = DEPTH_W'(diff);
    thr_evt_o = run_i && (level_o != depth_i);
  end
endmodule

// File: rtl/ethdma_irq_ctrl.sv
module ethdma_irq_ctrl
  import ethdma_irq_pkg::*;
#(
  parameter int TXPTR_W = 9,
  parameter int RXPTR_W = 4,
  parameter int SEQ_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         reg_addr,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               ev_tx_empty,
  input  logic               ev_tx_sent,
  input  logic               ev_link_fail,
  input  logic               ev_mem_err,
  input  logic               ev_tx_abort,
  input  logic               ev_rx_underflow,
  input  logic               ev_rx_overflow,
  input  logic [TXPTR_W-1:0] tx_rd_ptr,
  input  logic [RXPTR_W-1:0] rx_wr_ptr,
  input  logic [RXPTR_W-1:0] rx_rd_ptr,
  input  logic [SEQ_W-1:0]   rx_head_seq,
  output logic               irq,
  output logic               tx_dma_en,
  output logic               rx_dma_en,
  output logic [DEPTH_W-1:0] rx_depth_thr,
  output logic [OFF_W-1:0]   rx_data_offset
);
  reg_sel_e             sel;
  logic                 wr_status, wr_ctrl, fatal, thr_evt;
  logic [NUM_EVT-1:0]   set_vec, clr_vec, pend, en_mask;
  logic [CTRL_W-1:0]    ctrl;
  logic [DEPTH_W-1:0]   level;

  assign sel       = reg_sel_e'(reg_addr);
  assign wr_status = reg_wr && (sel == RS_STATUS);
  assign wr_ctrl   = reg_wr && (sel == RS_CTRL);

  always_comb begin
    set_vec              = '0;
    set_vec[EV_TX_EMPTY] = ev_tx_empty;
    set_vec[EV_TX_SENT]  = ev_tx_sent;
    set_vec[EV_LINK]     = ev_link_fail;
    set_vec[EV_MEM]      = ev_mem_err;
    set_vec[EV_ABORT]    = ev_tx_abort;
    set_vec[EV_RX_THR]   = thr_evt;
    set_vec[EV_RX_UNDER] = ev_rx_underflow;
    set_vec[EV_RX_OVER]  = ev_rx_overflow;
  end

  assign clr_vec = wr_status ? reg_wdata[NUM_EVT-1:0] : '0;
  assign fatal   = |(set_vec & FATAL_MASK);

  ethdma_pend_w1c #(.N(NUM_EVT)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .pend_o(pend)
  );

  ethdma_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_ctrl), .wdata_i(reg_wdata[CTRL_W-1:0]),
    .fatal_i(fatal), .ctrl_o(ctrl)
  );

  assign tx_dma_en      = ctrl[CB_TX_RUN];
  assign rx_dma_en      = ctrl[CB_RX_RUN];
  assign rx_depth_thr   = ctrl[CB_DEPTH_LSB +: DEPTH_W];
  assign rx_data_offset = ctrl[CB_OFF_LSB +: OFF_W];

  ethdma_rx_meter #(.PTR_W(RXPTR_W)) u_meter (
    .wr_ptr_i(rx_wr_ptr), .rd_ptr_i(rx_rd_ptr), .depth_i(rx_depth_thr),
    .run_i(rx_dma_en), .level_o(level), .thr_evt_o(thr_evt)
  );

  always_comb begin
    en_mask            = ALWAYS_MASK;
    en_mask[EV_TX_EMPTY] = ctrl[CB_TXE_IE];
    en_mask[EV_RX_THR]   = ctrl[CB_RX_IE];
  end

  assign irq = |(pend & en_mask);

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      RS_STATUS: begin
        reg_rdata[NUM_EVT-1:0]             = pend;
        reg_rdata[ST_RXPTR_LSB +: RXPTR_W] = rx_rd_ptr;
        reg_rdata[ST_TXPTR_LSB +: TXPTR_W] = tx_rd_ptr;
        reg_rdata[ST_SEQ_LSB +: SEQ_W]     = rx_head_seq;
      end
      RS_CTRL: reg_rdata[CTRL_W-1:0] = ctrl;
      RS_FIFO: begin
        reg_rdata[FI_WR_LSB +: RXPTR_W] = rx_wr_ptr;
        reg_rdata[FI_RD_LSB +: RXPTR_W] = rx_rd_ptr;
        reg_rdata[DEPTH_W-1:0]          = level;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ethdma_irq_ctrl_chk.sv
module ethdma_irq_ctrl_chk
  import ethdma_irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [1:0]         reg_addr,
  input logic [31:0]        reg_wdata,
  input logic [31:0]        reg_rdata,
  input logic [NUM_EVT-1:0] set_vec,
  input logic [NUM_EVT-1:0] pend,
  input logic               tx_dma_en,
  input logic               rx_dma_en,
  input logic               irq
);
  // R1
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));

  // R2
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && ((reg_wdata[NUM_EVT-1:0] & set_vec) == '0))
    |=> ((pend & $past(reg_wdata[NUM_EVT-1:0])) == '0));

  // R4
  fatal_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & FATAL_MASK) != '0) |=> (!tx_dma_en && !rx_dma_en));

  // R6
  err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ALWAYS_MASK) != '0) |-> irq);

  // R8
  status_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[15:12] == 4'd0 && reg_rdata[31:30] == 2'd0));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (pend == '0 && !tx_dma_en && !rx_dma_en));
endmodule

bind ethdma_irq_ctrl ethdma_irq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_vec(set_vec),
  .pend(pend), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en), .irq(irq)
);

// File: tb/ethdma_irq_ctrl_tb_top.sv
module ethdma_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ev_tx_empty = 0, ev_tx_sent = 0, ev_link_fail = 0, ev_mem_err = 0;
  logic ev_tx_abort = 0, ev_rx_underflow = 0, ev_rx_overflow = 0;
  logic [8:0] tx_rd_ptr = 9'h1A5;
  logic [3:0] rx_wr_ptr = '0, rx_rd_ptr = '0;
  logic [4:0] rx_head_seq = 5'h13;
  logic irq, tx_dma_en, rx_dma_en;
  logic [4:0] rx_depth_thr;
  logic [2:0] rx_data_offset;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  ethdma_irq_ctrl dut_i (.*);

  localparam logic [31:0] B = 32'h27A5_0000;
  // {wr, waddr[1:0], wdata[15:0], ev[7:0], raddr[1:0], exp[31:0], irq}
  localparam int NV = 22;
  localparam logic [61:0] VEC [NV] = '{
    {1'b0,2'd0,16'h0000,8'h01,2'd0,B|32'h01,1'b0}, // R1 tx empty, masked
    {1'b1,2'd1,16'h0001,8'h00,2'd0,B|32'h01,1'b1}, // R6 enable bit0
    {1'b1,2'd0,16'h0001,8'h00,2'd0,B,        1'b0}, // R2 clear
    {1'b0,2'd0,16'h0000,8'h02,2'd0,B|32'h02,1'b1}, // R1 R6 sent
    {1'b1,2'd0,16'h0000,8'h00,2'd0,B|32'h02,1'b1}, // R2 zero no effect
    {1'b1,2'd0,16'h0002,8'h02,2'd0,B|32'h02,1'b1}, // R3 collision
    {1'b1,2'd0,16'h0002,8'h00,2'd0,B,        1'b0}, // R2
    {1'b1,2'd1,16'h8003,8'h00,2'd1,32'h8003,1'b0}, // R5
    {1'b0,2'd0,16'h0000,8'h08,2'd1,32'h0001,1'b1}, // R4 mem err
    {1'b0,2'd0,16'h0000,8'h00,2'd0,B|32'h08,1'b1}, // R1
    {1'b1,2'd0,16'h0008,8'h00,2'd0,B,        1'b0}, // R2
    {1'b1,2'd1,16'h8003,8'h00,2'd1,32'h8003,1'b0}, // R5
    {1'b0,2'd0,16'h0000,8'h80,2'd1,32'h0001,1'b1}, // R4 overflow
    {1'b1,2'd0,16'h0080,8'h00,2'd0,B,        1'b0}, // R2
    {1'b1,2'd1,16'h000C,8'h00,2'd1,32'h0000,1'b0}, // R5 read-only bits
    {1'b0,2'd0,16'h0000,8'h04,2'd0,B|32'h04,1'b1}, // R6 link fail always on
    {1'b1,2'd0,16'h00FF,8'h00,2'd0,B,        1'b0}, // R2 clear all
    {1'b1,2'd1,16'h8002,8'h00,2'd1,32'h8002,1'b0}, // R5
    {1'b0,2'd0,16'h0000,8'h40,2'd1,32'h8002,1'b1}, // R4 underflow not fatal
    {1'b1,2'd0,16'h0040,8'h00,2'd0,B,        1'b0}, // R2
    {1'b0,2'd0,16'h0000,8'h10,2'd1,32'h0000,1'b1}, // R4 tx abort
    {1'b1,2'd0,16'h0010,8'h00,2'd3,32'h0000,1'b0}  // R8 unused address
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_ev(input logic [7:0] e);
    ev_tx_empty = e[0]; ev_tx_sent = e[1]; ev_link_fail = e[2]; ev_mem_err = e[3];
    ev_tx_abort = e[4]; ev_rx_underflow = e[6]; ev_rx_overflow = e[7];
  endtask

  // drive at negedge, let one edge pass, release at the next negedge
  task automatic apply(input logic wr, input logic [1:0] a, input logic [31:0] d,
                       input logic [7:0] e);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; set_ev(e);
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; set_ev(8'h00);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R10 reset state
    rd(2'd0, v); check("R10 status", v, B);
    rd(2'd1, v); check("R10 ctrl", v, 32'h0);
    check("R10 irq/en", {29'd0, irq, tx_dma_en, rx_dma_en}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [61:0] t;
      t = VEC[i];
      apply(t[61], t[60:59], {16'h0, t[58:43]}, t[42:35]);
      rd(t[34:33], v);
      check($sformatf("vector %0d rdata", i), v, t[32:1]);
      check($sformatf("vector %0d irq", i), {31'd0, irq}, {31'd0, t[0]});
    end

    // R7 R8 pointer aliases
    @(negedge clk); rx_wr_ptr = 4'd5; rx_rd_ptr = 4'd2;
    rd(2'd2, v); check("R7 fifo info", v, 32'h0005_0203);
    rd(2'd0, v); check("R8 status alias", v, B | 32'h200);

    // R9 threshold equal: no event
    apply(1'b1, 2'd1, 32'h8230, 8'h00);
    apply(1'b0, 2'd0, 32'h0, 8'h00);
    rd(2'd0, v); check("R9 level matches", v, B | 32'h200);
    check("R9 irq quiet", {31'd0, irq}, 32'd0);
    @(negedge clk); rx_wr_ptr = 4'd6;
    @(negedge clk);
    rd(2'd0, v); check("R9 level differs", v, B | 32'h220);
    check("R9 irq", {31'd0, irq}, 32'd1);
    @(negedge clk); rx_wr_ptr = 4'd5;
    apply(1'b1, 2'd0, 32'h20, 8'h00);
    rd(2'd0, v); check("R9 cleared stays", v, B | 32'h200);

    // R6 bit5 masked, R3 repeated event beats clear
    apply(1'b1, 2'd1, 32'h8030, 8'h00);
    @(negedge clk); rx_wr_ptr = 4'd6;
    apply(1'b1, 2'd0, 32'h20, 8'h00);
    rd(2'd0, v); check("R3 thr beats clear", v, B | 32'h220);
    check("R6 thr masked", {31'd0, irq}, 32'd0);
    @(negedge clk); rx_wr_ptr = 4'd5;
    apply(1'b1, 2'd0, 32'h20, 8'h00);

    // R7 wrap
    @(negedge clk); rx_wr_ptr = 4'd1; rx_rd_ptr = 4'd14;
    rd(2'd2, v); check("R7 wrap level", v, 32'h0001_0E03);

    // R5 offset pin
    apply(1'b1, 2'd1, 32'h5000, 8'h00);
    check("R5 pins", {24'd0, rx_data_offset, rx_depth_thr}, {24'd0, 3'd5, 5'd0});

    // R4 fatal overrides same-cycle write
    apply(1'b1, 2'd1, 32'h8002, 8'h08);
    rd(2'd1, v); check("R4 fatal vs write", v, 32'h0);
    check("R4 run pins", {30'd0, tx_dma_en, rx_dma_en}, 32'd0);
    apply(1'b1, 2'd0, 32'h08, 8'h00);

    // R10 reset mid-run
    apply(1'b0, 2'd0, 32'h0, 8'h01);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(2'd0, v); check("R10 mid-run status", v & 32'hFF, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule